// File: doc/BRIEF.md
# Real-Time-Clock Command and Status Register Unit

This unit is the register front end of a real-time-clock device that is reached through a byte-serial port. A transaction opens when the select line rises. The first byte shifted in is a command code. That code picks one register group and decides whether the transfer reads or writes it. Every byte after the command is data. All bytes travel least significant bit first, and one bit moves per strobe.

The unit holds two status registers and a date/time byte array. The time counter itself sits outside the unit, so the array is plain storage here. It also holds two interrupt-setting registers, a clock-adjust byte and a free byte. Each status bit follows its own access rule:
- some bits are scratch bits;
- one bit is write-only and restores every default;
- four flag bits are set by events and clear once software has read them.

Power-loss and low-power pulses from the environment drive the flags.

Top module: `rtc_cmd_regs`

## Requirements
- R1: While `cs` is high, each `bit_stb` pulse shifts one bit, least significant first. The first 8 bits form the command and later groups of 8 form data bytes. During a read, `sdo` presents bit k of the current data byte before the k-th strobe of that byte. `sdo` is 0 while `cs` is low and during the command byte.
- R2: Command codes are paired, and the direction is not always in the same order. Status 1 uses 0x60 to write and 0x61 to read. Status 2 uses 0x62 to write and 0x63 to read. The 7-byte date/time uses 0x64 to write and 0x65 to read. The 3-byte time uses 0x66 to write and 0x67 to read, and it maps onto date/time bytes 4..6. Interrupt setting 1 (3 bytes) uses 0x68 to write and 0x69 to read. Interrupt setting 2 (3 bytes) is reversed: 0x6B writes and 0x6A reads. The adjust byte uses 0x6D to write and 0x6C to read. The free byte uses 0x6F to write and 0x6E to read. Data sent after a read code is ignored.
- R3: Status 1 bit 1 and the scratch bits 2..3 can be written and read back. Writes to bits 4..7 have no effect, and bit 0 always reads 0.
- R4: Writing status 1 with bit 0 set restores every default and clears all flags, including the test bit. After that, every byte reads 0x00, except date/time bytes 1 and 2, which read 0x01.
- R5: A pulse on `irq1_evt` sets status 1 bit 4. A pulse on `irq2_evt` sets bit 5. A pulse on `power_low` sets bit 6. Each flag stays set until it is cleared.
- R6: Flag bits 4..7 clear when `cs` falls after at least one complete data byte of a status 1 read. A read that ends after the command byte leaves the flags set.
- R7: A flag event that arrives during a status 1 read is still set after that read clears the flags.
- R8: `rst_n` low or a `power_on_reset` pulse restores all defaults and sets status 1 bit 7, so status 1 reads 0x80.
- R9: All 8 bits of status 2 can be written and read back. `int1_mode` shows bits 3..0, `int2_alarm_en` shows bit 6 and `test_mode` shows bit 7.
- R10: A command whose upper nibble is not 0x6 is ignored: its data changes nothing and a read returns 0x00.
- R11: A data byte past the end of the selected register is not written, and reading it returns 0x00.
- R12: `hour_24` shows status 1 bit 1, where 1 means 24-hour mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, treated as a power-up |
| cs | input | 1 | Transaction select, high during a transfer |
| bit_stb | input | 1 | One-cycle strobe that moves one serial bit |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| power_on_reset | input | 1 | Pulse: power returned after a loss |
| power_low | input | 1 | Pulse: supply dropped below the safe level |
| irq1_evt | input | 1 | Pulse: interrupt 1 event |
| irq2_evt | input | 1 | Pulse: interrupt 2 event |
| hour_24 | output | 1 | 24-hour mode select |
| int1_mode | output | 4 | Interrupt 1 mode field |
| int2_alarm_en | output | 1 | Interrupt 2 alarm enable |
| test_mode | output | 1 | Test mode bit |

## Verification
The bench targets the three paths through the clear-on-read logic:
- A read aborted after the command byte must keep the flags. A design that clears on any end of a read would lose them.
- An event injected while a read is still selected must survive the clear. A design that clears blindly would drop it.
- A second read must show the flags gone. A design that never clears would show them again.

The reversed opcode pair for interrupt setting 2 is checked in both directions. The 3-byte time window is checked inside the 7-byte date/time array. Both catch a design that decodes direction from bit 0 alone or maps time to the wrong bytes. Bytes past a register's end, unknown codes, and the full default restore after a written reset bit are also checked. A design that wraps indices or leaves state behind would fail these.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [2:0] {
      RG_STAT1 = 3'd0,
      RG_STAT2 = 3'd1,
      RG_DTIME = 3'd2,
      RG_TIME  = 3'd3,
      RG_ALM1  = 3'd4,
      RG_ALM2  = 3'd5,
      RG_ADJ   = 3'd6,
      RG_FREE  = 3'd7
   } rtc_reg_e;

   typedef struct packed {
      logic     valid;
      logic     is_read;
      rtc_reg_e sel;
   } rtc_cmd_t;

   localparam logic [3:0] CMD_GROUP = 4'h6;
   // groups at or above this select read with an even code
   localparam logic [2:0] REVERSED_FROM = 3'd5;

   function automatic rtc_cmd_t rtc_decode(input logic [7:0] code);
      rtc_cmd_t d;
      d.valid   = (code[7:4] == CMD_GROUP);
      d.sel     = rtc_reg_e'(code[3:1]);
      d.is_read = (code[3:1] >= REVERSED_FROM) ? ~code[0] : code[0];
      return d;
   endfunction

   function automatic logic [7:0] dtime_default(input int idx);
      return (idx == 1 || idx == 2) ? 8'h01 : 8'h00;
   endfunction

endpackage

// File: rtl/rtc_serial_frame.sv
module rtc_serial_frame #(
   parameter int BIDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              bit_stb,
   input  logic              sdi,
   output logic              cs_fall,
   output logic              byte_done,
   output logic [7:0]        rx_byte,
   output logic [2:0]        bit_cnt,
   output logic [BIDX_W-1:0] byte_idx,
   output logic [7:0]        cmd_q
);
   localparam logic [BIDX_W-1:0] IDX_MAX = '1;

   logic       cs_q;
   logic [7:0] shreg;

   assign rx_byte   = {sdi, shreg[7:1]};
   assign byte_done = cs & bit_stb & (bit_cnt == 3'd7);
   assign cs_fall   = cs_q & ~cs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b0;
         shreg    <= '0;
         bit_cnt  <= '0;
         byte_idx <= '0;
         cmd_q    <= '0;
      end else begin
         cs_q <= cs;
         if (!cs) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
         end else if (bit_stb) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               if (byte_idx == '0) cmd_q <= rx_byte;
               if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_byte_bank.sv
module rtc_byte_bank #(
   parameter int                  NBYTES  = 1,
   parameter int                  IDX_W   = 5,
   parameter logic [NBYTES*8-1:0] DEFAULT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_byte
);
   logic [7:0] mem [NBYTES];

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= DEFAULT[g*8 +: 8];
         else if (clr)
            mem[g] <= DEFAULT[g*8 +: 8];
         else if (wr_en && wr_idx == IDX_W'(g))
            mem[g] <= wr_data;
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < NBYTES; i++)
         if (rd_idx == IDX_W'(i)) rd_byte = mem[i];
   end
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_pulse,
   input  logic       wr1_en,
   input  logic       wr2_en,
   input  logic [7:0] wr_data,
   input  logic       irq1_evt,
   input  logic       irq2_evt,
   input  logic       power_low,
   input  logic       rd1_active,
   input  logic       rd1_commit,
   output logic [7:0] stat1_rd,
   output logic [7:0] stat2_q,
   output logic       soft_rst
);
   // flags[3] power-off, [2] power-low, [1] irq2, [0] irq1
   logic [3:0] flags, late, evt;
   logic [2:0] ctl;          // status 1 bits 3..1

   assign evt      = {1'b0, power_low, irq2_evt, irq1_evt};
   assign soft_rst = wr1_en & wr_data[0];
   assign stat1_rd = {flags, ctl, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= 4'b1000;
         late    <= '0;
         ctl     <= '0;
         stat2_q <= '0;
      end else begin
         late <= rd1_active ? (late | evt) : '0;
         if (por_pulse) begin
            flags   <= 4'b1000 | evt;
            ctl     <= '0;
            stat2_q <= '0;
         end else if (soft_rst) begin
            flags   <= evt;
            ctl     <= '0;
            stat2_q <= '0;
         end else begin
            if (rd1_commit) flags <= late | evt;
            else            flags <= flags | evt;
            if (wr1_en) ctl     <= wr_data[3:1];
            if (wr2_en) stat2_q <= wr_data;
         end
      end
   end
endmodule

// File: rtl/rtc_cmd_regs.sv
module rtc_cmd_regs #(
   parameter int DT_BYTES    = 7,
   parameter int TIME_BYTES  = 3,
   parameter int ALARM_BYTES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs,
   input  logic       bit_stb,
   input  logic       sdi,
   output logic       sdo,
   input  logic       power_on_reset,
   input  logic       power_low,
   input  logic       irq1_evt,
   input  logic       irq2_evt,
   output logic       hour_24,
   output logic [3:0] int1_mode,
   output logic       int2_alarm_en,
   output logic       test_mode
);
   import rtc_pkg::*;

   localparam int BIDX_W    = $clog2(DT_BYTES + 2) + 1;
   localparam int TIME_BASE = DT_BYTES - TIME_BYTES;

   function automatic logic [DT_BYTES*8-1:0] dt_defaults();
      logic [DT_BYTES*8-1:0] v;
      for (int i = 0; i < DT_BYTES; i++) v[i*8 +: 8] = dtime_default(i);
      return v;
   endfunction

   if (TIME_BYTES > DT_BYTES) begin : g_bad_time
      $error("TIME_BYTES must not exceed DT_BYTES");
   end
   if (ALARM_BYTES < 1 || DT_BYTES < 1) begin : g_bad_len
      $error("register lengths must be at least one byte");
   end

   logic              cs_fall, byte_done;
   logic [7:0]        rx_byte, cmd_q;
   logic [2:0]        bit_cnt;
   logic [BIDX_W-1:0] byte_idx, didx;
   rtc_cmd_t          dec;

   rtc_serial_frame #(.BIDX_W(BIDX_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs(cs), .bit_stb(bit_stb), .sdi(sdi),
      .cs_fall(cs_fall), .byte_done(byte_done), .rx_byte(rx_byte),
      .bit_cnt(bit_cnt), .byte_idx(byte_idx), .cmd_q(cmd_q)
   );

   assign dec  = rtc_decode(cmd_q);
   assign didx = byte_idx - 1'b1;

   logic in_data, wr_fire, rd_on;
   assign in_data = cs & (byte_idx != '0) & dec.valid;
   assign wr_fire = byte_done & in_data & ~dec.is_read;
   assign rd_on   = in_data & dec.is_read;

   logic rd1_active, rd1_commit, soft_rst;
   assign rd1_active = rd_on & (dec.sel == RG_STAT1);
   assign rd1_commit = cs_fall & dec.valid & dec.is_read &
                       (dec.sel == RG_STAT1) & (byte_idx >= BIDX_W'(2));

   logic [7:0] stat1_rd, stat2_q;
   logic       first_byte;
   assign first_byte = (didx == '0);

   rtc_status_regs u_status (
      .clk(clk), .rst_n(rst_n), .por_pulse(power_on_reset),
      .wr1_en(wr_fire & first_byte & (dec.sel == RG_STAT1)),
      .wr2_en(wr_fire & first_byte & (dec.sel == RG_STAT2)),
      .wr_data(rx_byte), .irq1_evt(irq1_evt), .irq2_evt(irq2_evt),
      .power_low(power_low), .rd1_active(rd1_active),
      .rd1_commit(rd1_commit), .stat1_rd(stat1_rd), .stat2_q(stat2_q),
      .soft_rst(soft_rst)
   );

   logic bank_clr;
   assign bank_clr = soft_rst | power_on_reset;

   // date/time array: full window or the trailing time window
   logic [BIDX_W-1:0] dt_idx;
   logic              dt_hit;
   logic [7:0]        dt_rd;
   always_comb begin
      dt_idx = didx;
      dt_hit = 1'b0;
      if (dec.sel == RG_DTIME) begin
         dt_hit = (didx < BIDX_W'(DT_BYTES));
      end else if (dec.sel == RG_TIME) begin
         dt_hit = (didx < BIDX_W'(TIME_BYTES));
         dt_idx = didx + BIDX_W'(TIME_BASE);
      end
   end

   rtc_byte_bank #(.NBYTES(DT_BYTES), .IDX_W(BIDX_W), .DEFAULT(dt_defaults())) u_dtime (
      .clk(clk), .rst_n(rst_n), .clr(bank_clr), .wr_en(wr_fire & dt_hit),
      .wr_idx(dt_idx), .wr_data(rx_byte), .rd_idx(dt_idx), .rd_byte(dt_rd)
   );

   // two interrupt-setting banks of identical shape
   logic [7:0] alm_rd [2];
   for (genvar a = 0; a < 2; a++) begin : g_alarm
      localparam rtc_reg_e SEL = (a == 0) ? RG_ALM1 : RG_ALM2;
      rtc_byte_bank #(.NBYTES(ALARM_BYTES), .IDX_W(BIDX_W)) u_alm (
         .clk(clk), .rst_n(rst_n), .clr(bank_clr),
         .wr_en(wr_fire & (dec.sel == SEL)), .wr_idx(didx),
         .wr_data(rx_byte), .rd_idx(didx), .rd_byte(alm_rd[a])
      );
   end

   logic [7:0] adj_rd, free_rd;
   rtc_byte_bank #(.NBYTES(1), .IDX_W(BIDX_W)) u_adj (
      .clk(clk), .rst_n(rst_n), .clr(bank_clr),
      .wr_en(wr_fire & (dec.sel == RG_ADJ)), .wr_idx(didx),
      .wr_data(rx_byte), .rd_idx(didx), .rd_byte(adj_rd)
   );
   rtc_byte_bank #(.NBYTES(1), .IDX_W(BIDX_W)) u_free (
      .clk(clk), .rst_n(rst_n), .clr(bank_clr),
      .wr_en(wr_fire & (dec.sel == RG_FREE)), .wr_idx(didx),
      .wr_data(rx_byte), .rd_idx(didx), .rd_byte(free_rd)
   );

   logic [7:0] rd_byte;
   always_comb begin
      rd_byte = '0;
      unique case (dec.sel)
         RG_STAT1: rd_byte = first_byte ? stat1_rd : 8'h00;
         RG_STAT2: rd_byte = first_byte ? stat2_q  : 8'h00;
         RG_DTIME,
         RG_TIME:  rd_byte = dt_hit ? dt_rd : 8'h00;
         RG_ALM1:  rd_byte = alm_rd[0];
         RG_ALM2:  rd_byte = alm_rd[1];
         RG_ADJ:   rd_byte = adj_rd;
         RG_FREE:  rd_byte = free_rd;
         default:  rd_byte = '0;
      endcase
   end

   assign sdo           = rd_on & rd_byte[bit_cnt];
   assign hour_24       = stat1_rd[1];
   assign int1_mode     = stat2_q[3:0];
   assign int2_alarm_en = stat2_q[6];
   assign test_mode     = stat2_q[7];
endmodule

// File: rtl/rtc_cmd_regs_chk.sv
module rtc_cmd_regs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs,
   input logic       sdo,
   input logic       power_on_reset,
   input logic       power_low,
   input logic       irq1_evt,
   input logic       irq2_evt,
   input logic [7:0] stat1_rd,
   input logic       test_mode,
   input logic       soft_rst,
   input logic       rd1_commit
);
   p_sdo_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sdo);

   p_por_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      power_on_reset |=> stat1_rd[7]);

   p_lowpwr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      power_low |=> stat1_rd[6]);

   p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat1_rd[4] && !rd1_commit && !soft_rst && !power_on_reset) |=> stat1_rd[4]);

   p_soft_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !power_on_reset && !power_low && !irq1_evt && !irq2_evt)
      |=> (stat1_rd == 8'h00 && !test_mode));

   p_late_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd1_commit && irq2_evt) |=> stat1_rd[5]);
endmodule

bind rtc_cmd_regs rtc_cmd_regs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .sdo(sdo),
   .power_on_reset(power_on_reset), .power_low(power_low),
   .irq1_evt(irq1_evt), .irq2_evt(irq2_evt), .stat1_rd(stat1_rd),
   .test_mode(test_mode), .soft_rst(soft_rst), .rd1_commit(rd1_commit)
);

// File: tb/rtc_cmd_regs_bench.sv
module rtc_cmd_regs_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, bit_stb = 1'b0, sdi = 1'b0;
   logic power_on_reset = 1'b0, power_low = 1'b0, irq1_evt = 1'b0, irq2_evt = 1'b0;
   logic sdo, hour_24, int2_alarm_en, test_mode;
   logic [3:0] int1_mode;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [7:0] tx_buf [8];
   logic [7:0] rx_buf [8];

   always #2 clk = ~clk;

   rtc_cmd_regs u_rtc_cmd_regs (
      .clk(clk), .rst_n(rst_n), .cs(cs), .bit_stb(bit_stb), .sdi(sdi), .sdo(sdo),
      .power_on_reset(power_on_reset), .power_low(power_low),
      .irq1_evt(irq1_evt), .irq2_evt(irq2_evt), .hour_24(hour_24),
      .int1_mode(int1_mode), .int2_alarm_en(int2_alarm_en), .test_mode(test_mode)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         r[k] = sdo;
         sdi = b[k];
         bit_stb = 1'b1;
         @(negedge clk);
         bit_stb = 1'b0;
      end
   endtask

   task automatic txn(input logic [7:0] cmd, input int n, input bit inj_late);
      logic [7:0] dummy;
      @(negedge clk) cs = 1'b1;
      send_byte(cmd, dummy);
      for (int i = 0; i < n; i++) send_byte(tx_buf[i], rx_buf[i]);
      if (inj_late) begin
         @(negedge clk) irq2_evt = 1'b1;
         @(negedge clk) irq2_evt = 1'b0;
      end
      @(negedge clk) cs = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wr1(input logic [7:0] cmd, input logic [7:0] v);
      tx_buf[0] = v;
      txn(cmd, 1, 1'b0);
   endtask

   task automatic rd1(input logic [7:0] cmd, output logic [7:0] v);
      tx_buf[0] = 8'h00;
      txn(cmd, 1, 1'b0);
      v = rx_buf[0];
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: irq1_evt = 1'b1;
         1: irq2_evt = 1'b1;
         2: power_low = 1'b1;
         default: power_on_reset = 1'b1;
      endcase
      @(negedge clk);
      irq1_evt = 1'b0; irq2_evt = 1'b0; power_low = 1'b0; power_on_reset = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 sdo idle after reset", {7'd0, sdo}, 8'h00);
      check("R12 hour_24 reset", {7'd0, hour_24}, 8'h00);
      check("R9 test_mode reset", {7'd0, test_mode}, 8'h00);
      rd1(8'h61, v); check("R8 status1 after reset", v, 8'h80);
      rd1(8'h61, v); check("R6 power-off flag cleared by read", v, 8'h00);
   endtask

   task automatic t_status();
      logic [7:0] v;
      wr1(8'h60, 8'hFE);
      rd1(8'h61, v); check("R3 status1 writable bits", v, 8'h0E);
      check("R12 hour_24 set", {7'd0, hour_24}, 8'h01);
      wr1(8'h62, 8'hC5);
      rd1(8'h63, v); check("R9 status2 readback", v, 8'hC5);
      check("R9 int1_mode", {4'd0, int1_mode}, 8'h05);
      check("R9 int2_alarm_en", {7'd0, int2_alarm_en}, 8'h01);
      check("R9 test_mode", {7'd0, test_mode}, 8'h01);
   endtask

   task automatic t_dtime();
      logic [7:0] pat [7] = '{8'h24, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h58};
      for (int i = 0; i < 7; i++) tx_buf[i] = pat[i];
      txn(8'h64, 7, 1'b0);
      for (int i = 0; i < 7; i++) tx_buf[i] = 8'h00;
      txn(8'h65, 7, 1'b0);
      for (int i = 0; i < 7; i++) check("R2 date/time readback", rx_buf[i], pat[i]);
      tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
      txn(8'h66, 3, 1'b0);
      for (int i = 0; i < 7; i++) tx_buf[i] = 8'h00;
      txn(8'h65, 7, 1'b0);
      check("R2 time write keeps date byte 3", rx_buf[3], 8'h02);
      check("R2 time write lands in byte 4", rx_buf[4], 8'h11);
      check("R2 time write lands in byte 6", rx_buf[6], 8'h33);
      txn(8'h67, 4, 1'b0);
      check("R2 time read byte 0", rx_buf[0], 8'h11);
      check("R2 time read byte 2", rx_buf[2], 8'h33);
      check("R11 time read past end", rx_buf[3], 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] v;
      tx_buf[0] = 8'hA1; tx_buf[1] = 8'hA2; tx_buf[2] = 8'hA3;
      txn(8'h68, 3, 1'b0);
      tx_buf[0] = 8'hB1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hB3;
      txn(8'h6B, 3, 1'b0);
      tx_buf[0] = 8'hEE; tx_buf[1] = 8'hEE; tx_buf[2] = 8'hEE;
      txn(8'h6A, 3, 1'b0);
      check("R2 read code 0x6A returns int2 byte 0", rx_buf[0], 8'hB1);
      txn(8'h6A, 3, 1'b0);
      check("R2 int2 byte 2 unchanged after read code", rx_buf[2], 8'hB3);
      txn(8'h69, 3, 1'b0);
      check("R2 int1 byte 1", rx_buf[1], 8'hA2);
      wr1(8'h6D, 8'h3C);
      rd1(8'h6C, v); check("R2 adjust readback", v, 8'h3C);
      tx_buf[0] = 8'h5A; tx_buf[1] = 8'h77;
      txn(8'h6F, 2, 1'b0);
      txn(8'h6E, 2, 1'b0);
      check("R2 free readback", rx_buf[0], 8'h5A);
      check("R11 free second byte", rx_buf[1], 8'h00);
   endtask

   task automatic t_unknown();
      logic [7:0] v;
      wr1(8'h40, 8'hFF);
      wr1(8'h70, 8'h01);
      rd1(8'h41, v); check("R10 unknown read", v, 8'h00);
      rd1(8'h6E, v); check("R10 free untouched", v, 8'h5A);
      rd1(8'h61, v); check("R10 status1 untouched", v, 8'h0E);
   endtask

   task automatic t_flags();
      logic [7:0] v;
      pulse(0); pulse(2);
      rd1(8'h61, v); check("R5 irq1 and power-low flags", v, 8'h5E);
      rd1(8'h61, v); check("R6 flags cleared after read", v, 8'h0E);
      pulse(1);
      txn(8'h61, 0, 1'b0);
      rd1(8'h61, v); check("R6 aborted read keeps irq2", v, 8'h2E);
      pulse(0);
      tx_buf[0] = 8'h00;
      txn(8'h61, 1, 1'b1);
      check("R7 read before late event", rx_buf[0], 8'h1E);
      rd1(8'h61, v); check("R7 late irq2 kept", v, 8'h2E);
      rd1(8'h61, v); check("R6 all flags cleared", v, 8'h0E);
   endtask

   task automatic t_softrst();
      logic [7:0] v;
      wr1(8'h60, 8'h01);
      rd1(8'h61, v); check("R4 status1 default", v, 8'h00);
      check("R4 hour_24 default", {7'd0, hour_24}, 8'h00);
      rd1(8'h63, v); check("R4 status2 default", v, 8'h00);
      check("R4 test_mode cleared", {7'd0, test_mode}, 8'h00);
      txn(8'h65, 7, 1'b0);
      check("R4 date byte 0", rx_buf[0], 8'h00);
      check("R4 date byte 1", rx_buf[1], 8'h01);
      check("R4 date byte 2", rx_buf[2], 8'h01);
      check("R4 time byte 6", rx_buf[6], 8'h00);
      rd1(8'h6E, v); check("R4 free default", v, 8'h00);
   endtask

   task automatic t_por();
      logic [7:0] v;
      wr1(8'h62, 8'h80);
      wr1(8'h6D, 8'h44);
      pulse(3);
      rd1(8'h61, v); check("R8 power-off flag after pulse", v, 8'h80);
      rd1(8'h63, v); check("R8 status2 default", v, 8'h00);
      rd1(8'h6C, v); check("R8 adjust default", v, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_status();
      t_dtime();
      t_regs();
      t_unknown();
      t_flags();
      t_softrst();
      t_por();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule